// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous page-mode DRAM alive and brings it up after power-on. Leaving reset, it first waits out a fixed settling pause. It then runs a burst of dummy refresh cycles and raises a ready flag. From then on it issues one refresh at an even rate. Every refresh uses the CAS-before-RAS scheme: the DRAM's own row counter picks the row, so no address is driven and the data pins stay released.

The sequencer does not own the memory pins. It raises a request to the access controller and waits for the grant. Once granted, it signals that it has taken the strobes, and the controller then leaves the address and data buses undriven. Refreshes that cannot be issued because the grant is late are counted, up to a limit. When the grant comes they are issued back to back. All timings are parameters in clock cycles. The precharge phase is stretched to the largest of the RAS precharge, the RAS-precharge-to-CAS hold and the full-cycle minimum.

Top module: `cbr_refresh_seq`

## Requirements
- R1: During and just after reset, RAS#, CAS# and WE# are high, and request, ready and bus-ownership outputs are low.
- R2: For the first PAUSE_CYC clock cycles after reset is released, no request is raised and no strobe goes low.
- R3: Exactly INIT_CNT refresh cycles complete before ready goes high, and once high ready stays high.
- R4: In each refresh cycle CAS# falls first and stays low for exactly T_CSR cycles with RAS# high before RAS# falls.
- R5: After RAS# falls, CAS# stays low for exactly T_CHR cycles and then rises while RAS# is still low. RAS# stays low for exactly T_RAS cycles, and CAS# never falls while RAS# is low.
- R6: WE# is high at all times.
- R7: Between back-to-back refresh cycles both strobes are high for exactly T_PRE = max(T_RP, T_RPC, T_RC - T_RAS - T_CSR) cycles. Successive RAS# falls are therefore T_CSR + T_RAS + T_PRE cycles apart.
- R8: The request stays high until a refresh is granted. A strobe is low only while grant and the bus-ownership output are both high.
- R9: After ready, with grant held high, successive refresh cycles start exactly INTERVAL_CYC cycles apart.
- R10: While grant is withheld, owed refreshes accumulate up to MAX_PEND. Once grant returns they are issued back to back, and after they drain the request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gnt_i | input | 1 | Bus grant from the access controller |
| req_o | output | 1 | Refresh owed, asking for the bus |
| ready_o | output | 1 | Memory initialised, normal accesses allowed |
| bus_own_o | output | 1 | Sequencer drives the strobes; address and data stay undriven |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |

## Verification
The initialisation burst is first held off by a withheld grant. This shows that the request persists and that the pause and init count are independent of when the grant comes. With the grant always high, the spacing of refreshes isolates the interval timer from the back-to-back path. A long grant outage followed by a release checks that owed refreshes saturate and then drain at the tight back-to-back spacing. Every observed cycle is measured for its CAS lead, CAS hold, RAS width and precharge. A reordered or RAS-only strobe pattern therefore shows up in any of these patterns.

// File: rtl/cbr_pkg.sv
// Shared types for the refresh sequencer.
// Engine state codes carry the strobe levels: bit 2 is RAS#, bit 1 is CAS#,
// so both strobes come straight from flops with no decode.
package cbr_pkg;

    typedef enum logic [2:0] {
        ES_IDLE   = 3'b110,
        ES_PRE    = 3'b111,
        ES_CSU    = 3'b100,
        ES_ACT_CL = 3'b000,
        ES_ACT_CH = 3'b010
    } eng_state_t;

    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_INIT  = 2'd1,
        PH_RUN   = 2'd2
    } phase_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cbr_timebase.sv
// Power-up pause counter and refresh interval timer.
// Assumes PAUSE_CYC >= 1 and INTERVAL_CYC >= 2. The pause pulse fires once
// after reset; the interval timer runs only while run_i is high.
module cbr_timebase #(
    parameter int PAUSE_CYC    = 20000,
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic pause_done_o,
    output logic tick_o
);
    localparam int PCW = $clog2(PAUSE_CYC + 1);
    localparam int ICW = $clog2(INTERVAL_CYC + 1);

    logic [PCW-1:0] pcnt_q;
    logic           pdone_q;
    logic [ICW-1:0] icnt_q;

    assign pause_done_o = !pdone_q && (pcnt_q == PCW'(PAUSE_CYC - 1));
    assign tick_o       = run_i && (icnt_q == ICW'(INTERVAL_CYC - 1));

    // Count the settling pause once after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q  <= '0;
            pdone_q <= 1'b0;
        end else if (pause_done_o) begin
            pdone_q <= 1'b1;
        end else if (!pdone_q) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // Free-running refresh interval while in normal operation.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) icnt_q <= '0;
        else if (tick_o)      icnt_q <= '0;
        else                  icnt_q <= icnt_q + 1'b1;
    end

    // R9
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/cbr_pending.sv
// Counter of refreshes owed. It is loaded with the init burst length when the
// pause ends, saturates at MAX_PEND on interval ticks, and counts down by one
// per refresh started. Assumes ticks do not arrive during the init burst.
module cbr_pending #(
    parameter int MAX_PEND = 8,
    parameter int INIT_CNT = 8,
    parameter int PW       = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic tick_i,
    input  logic dec_i,
    output logic pend_nz_o
);
    logic [PW-1:0] pend_q;

    assign pend_nz_o = (pend_q != '0);

    // Track owed refreshes with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend_q <= '0;
        else if (load_i)            pend_q <= PW'(INIT_CNT);
        else if (tick_i && !dec_i) begin
            if (pend_q < PW'(MAX_PEND)) pend_q <= pend_q + 1'b1;
        end else if (dec_i && !tick_i) pend_q <= pend_q - 1'b1;
    end

    // R10
    pend_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !dec_i && !load_i && pend_q == PW'(MAX_PEND) |=> pend_q == PW'(MAX_PEND));

    // R10
    pend_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> pend_q != '0);

endmodule

// File: rtl/cbr_engine.sv
// Strobe engine for one or more CAS-before-RAS cycles.
// Phases: CAS lead (T_CSR), RAS low with CAS low (T_CHR), RAS low with CAS
// high (T_RAS - T_CHR), precharge (T_PRE). Assumes T_RAS > T_CHR >= 1,
// T_CSR >= 1 and T_PRE >= 1. A new cycle starts only with grant held.
module cbr_engine
    import cbr_pkg::*;
#(
    parameter int T_CSR = 1,
    parameter int T_CHR = 1,
    parameter int T_RAS = 5,
    parameter int T_PRE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt_i,
    input  logic pend_nz_i,
    output logic start_o,
    output logic own_o,
    output logic ras_n_o,
    output logic cas_n_o
);
    localparam int LONGEST = max2(max2(T_CSR, T_RAS), T_PRE);
    localparam int CW      = $clog2(LONGEST + 1);

    eng_state_t     st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d, len;
    logic           last;

    assign ras_n_o = st_q[2];
    assign cas_n_o = st_q[1];
    assign own_o   = (st_q != ES_IDLE);

    // Length of the current phase.
    always_comb begin
        case (st_q)
            ES_CSU:    len = CW'(T_CSR);
            ES_ACT_CL: len = CW'(T_CHR);
            ES_ACT_CH: len = CW'(T_RAS - T_CHR);
            ES_PRE:    len = CW'(T_PRE);
            default:   len = CW'(1);
        endcase
    end

    assign last = (cnt_q == len - 1'b1);

    // Phase sequencing and start decision.
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q + 1'b1;
        start_o = 1'b0;
        case (st_q)
            ES_IDLE: begin
                cnt_d = '0;
                if (gnt_i && pend_nz_i) begin
                    st_d    = ES_CSU;
                    start_o = 1'b1;
                end
            end
            ES_CSU:    if (last) begin st_d = ES_ACT_CL; cnt_d = '0; end
            ES_ACT_CL: if (last) begin st_d = ES_ACT_CH; cnt_d = '0; end
            ES_ACT_CH: if (last) begin st_d = ES_PRE;    cnt_d = '0; end
            ES_PRE: begin
                if (last) begin
                    cnt_d = '0;
                    if (gnt_i && pend_nz_i) begin
                        st_d    = ES_CSU;
                        start_o = 1'b1;
                    end else begin
                        st_d = ES_IDLE;
                    end
                end
            end
            default: begin
                st_d  = ES_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // State and phase counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ES_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // R4
    cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> !cas_n_o && !$past(cas_n_o));

    // R5
    no_cas_fall_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o && !$past(ras_n_o) |-> !$fell(cas_n_o));

    // R8
    start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n_o) && $past(st_q == ES_IDLE) |-> $past(gnt_i));

endmodule

// File: rtl/cbr_refresh_seq.sv
// Top of the refresh and power-up sequencer. Phases: pause, init burst,
// normal running. Ready is high only in normal running. While bus_own_o is
// high the access controller must pass these strobes to the DRAM and leave
// address and data undriven. Assumes grant, once given, stays high while
// req_o is high or until the sequencer releases the bus.
module cbr_refresh_seq
    import cbr_pkg::*;
#(
    parameter int PAUSE_CYC    = 20000,
    parameter int INIT_CNT     = 8,
    parameter int INTERVAL_CYC = 1560,
    parameter int MAX_PEND     = 8,
    parameter int T_CSR        = 1,
    parameter int T_CHR        = 1,
    parameter int T_RAS        = 5,
    parameter int T_RP         = 3,
    parameter int T_RPC        = 1,
    parameter int T_RC         = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt_i,
    output logic req_o,
    output logic ready_o,
    output logic bus_own_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o
);
    localparam int T_PRE  = max2(max2(T_RP, T_RPC), T_RC - T_RAS - T_CSR);
    localparam int PW     = $clog2(max2(INIT_CNT, MAX_PEND) + 1);

    phase_t phase_q;
    logic   pause_done, tick, start, pend_nz;

    assign ready_o = (phase_q == PH_RUN);
    assign req_o   = pend_nz;
    assign we_n_o  = 1'b1;

    cbr_timebase #(
        .PAUSE_CYC    (PAUSE_CYC),
        .INTERVAL_CYC (INTERVAL_CYC)
    ) i_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (ready_o),
        .pause_done_o (pause_done),
        .tick_o       (tick)
    );

    cbr_pending #(
        .MAX_PEND  (MAX_PEND),
        .INIT_CNT  (INIT_CNT),
        .PW        (PW)
    ) i_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (pause_done),
        .tick_i    (tick),
        .dec_i     (start),
        .pend_nz_o (pend_nz)
    );

    cbr_engine #(
        .T_CSR     (T_CSR),
        .T_CHR     (T_CHR),
        .T_RAS     (T_RAS),
        .T_PRE     (T_PRE)
    ) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt_i     (gnt_i),
        .pend_nz_i (pend_nz),
        .start_o   (start),
        .own_o     (bus_own_o),
        .ras_n_o   (ras_n_o),
        .cas_n_o   (cas_n_o)
    );

    // Advance pause -> init burst -> normal running.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_PAUSE;
        else begin
            case (phase_q)
                PH_PAUSE: if (pause_done) phase_q <= PH_INIT;
                PH_INIT:  if (!pend_nz && !bus_own_o) phase_q <= PH_RUN;
                default:  phase_q <= PH_RUN;
            endcase
        end
    end

    // R2
    quiet_in_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_PAUSE |-> !req_o && !bus_own_o && ras_n_o && cas_n_o);

    // R3
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

endmodule

// File: tb/test_cbr_refresh_seq.sv
module test_cbr_refresh_seq;

    localparam int CLK_PERIOD = 10;
    localparam int PAUSE      = 50;
    localparam int INIT       = 8;
    localparam int INTERVAL   = 100;
    localparam int MAXP       = 3;
    localparam int CSR        = 2;
    localparam int CHR        = 2;
    localparam int RAS        = 5;
    localparam int RP         = 3;
    localparam int RPC        = 2;
    localparam int RC         = 12;
    // Precharge by R7: max(3, 2, 12-5-2) = 5; spacing 2+5+5 = 12.
    localparam int PRE        = 5;
    localparam int SPACE      = CSR + RAS + PRE;

    typedef struct {
        int    pre;
        int    gap;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic gnt;
    logic req, ready, own, ras_n, cas_n, we_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int cyc   = 0;

    exp_t sb[$];

    int n_seen = 0;
    int first_cas_t = -1;
    int we_bad = 0, own_bad = 0, pause_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbr_refresh_seq #(
        .PAUSE_CYC (PAUSE), .INIT_CNT (INIT), .INTERVAL_CYC (INTERVAL),
        .MAX_PEND (MAXP), .T_CSR (CSR), .T_CHR (CHR), .T_RAS (RAS),
        .T_RP (RP), .T_RPC (RPC), .T_RC (RC)
    ) i_cbr_refresh_seq (
        .clk (clk), .rst_n (rst_n), .gnt_i (gnt), .req_o (req),
        .ready_o (ready), .bus_own_o (own), .ras_n_o (ras_n),
        .cas_n_o (cas_n), .we_n_o (we_n)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic push(input int pre, input int gap, input string tag);
        exp_t e;
        e.pre = pre; e.gap = gap; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) if (rst_n === 1'b1) cyc <= cyc + 1;

    // Monitor: measure every refresh cycle and compare with the scoreboard.
    logic p_ras = 1'b1, p_cas = 1'b1;
    int csr_n, chr_n, ras_n_cnt, cur_pre = -1, cur_gap = -1;
    int fall_t = 0, rise_t = 0;
    bit have_fall = 0, have_rise = 0;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (we_n !== 1'b1) we_bad++;
            if ((!ras_n || !cas_n) && (!gnt || !own)) own_bad++;
            if ((!ras_n || !cas_n || req) && cyc < PAUSE) pause_bad++;
            if (!cas_n && p_cas && ras_n) begin
                csr_n = 0; chr_n = 0; ras_n_cnt = 0;
                cur_pre = have_rise ? cyc - rise_t : -1;
                if (first_cas_t < 0) first_cas_t = cyc;
            end
            if (!cas_n && ras_n)  csr_n++;
            if (!cas_n && !ras_n) chr_n++;
            if (!ras_n)           ras_n_cnt++;
            if (!ras_n && p_ras) begin
                cur_gap = have_fall ? cyc - fall_t : -1;
                fall_t = cyc; have_fall = 1;
            end
            if (ras_n && !p_ras) begin
                rise_t = cyc; have_rise = 1; n_seen++;
                if (sb.size() == 0) begin
                    check(0, "R8", "unexpected refresh cycle", n_seen, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(csr_n == CSR, "R4", "CAS lead before RAS", csr_n, CSR);
                    check(chr_n == CHR, "R5", "CAS hold after RAS", chr_n, CHR);
                    check(ras_n_cnt == RAS, "R5", "RAS low width", ras_n_cnt, RAS);
                    if (e.pre >= 0) check(cur_pre == e.pre, "R7", "precharge", cur_pre, e.pre);
                    if (e.gap >= 0) check(cur_gap == e.gap, e.tag, "RAS fall spacing", cur_gap, e.gap);
                end
            end
            p_ras = ras_n;
            p_cas = cas_n;
        end
    end

    task automatic drain();
        for (int i = 0; i < 2000 && sb.size() != 0; i++) @(negedge clk);
        #1;
        check(sb.size() == 0, "R8", "scoreboard drained", sb.size(), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        gnt   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(ras_n === 1'b1 && cas_n === 1'b1, "R1", "strobes high in reset", {ras_n, cas_n}, 3);
        check(we_n === 1'b1, "R1", "WE high in reset", we_n, 1);
        check(req === 1'b0 && ready === 1'b0 && own === 1'b0, "R1", "req/ready/own low", {req, ready, own}, 0);
        rst_n = 1'b1;

        // R2 pause: still quiet just before the pause ends.
        repeat (PAUSE - 5) @(negedge clk);
        check(req === 1'b0, "R2", "no request in pause", req, 0);
        check(ready === 1'b0, "R2", "not ready in pause", ready, 0);

        // R8 request held while the grant is withheld.
        repeat (30) @(negedge clk);
        check(req === 1'b1, "R8", "request held without grant", req, 1);
        check(own === 1'b0 && ras_n === 1'b1 && cas_n === 1'b1, "R8", "no strobes without grant", own, 0);
        check(ready === 1'b0, "R3", "not ready before init burst", ready, 0);

        // R3 / R7 init burst, back to back.
        push(-1, -1, "R7");
        for (int i = 1; i < INIT; i++) push(PRE, SPACE, "R7");
        gnt = 1'b1;
        for (int i = 0; i < 1000 && !ready; i++) @(negedge clk);
        check(ready === 1'b1, "R3", "ready after init", ready, 1);
        check(n_seen == INIT, "R3", "cycles before ready", n_seen, INIT);
        check(first_cas_t >= PAUSE, "R2", "first CAS after pause", first_cas_t, PAUSE);
        check(sb.size() == 0, "R3", "init items left", sb.size(), 0);

        // R9 steady interval with grant always high.
        push(-1, -1, "R9");
        push(-1, INTERVAL, "R9");
        push(-1, INTERVAL, "R9");
        drain();
        gnt = 1'b0;
        check(ready === 1'b1, "R3", "ready stays high", ready, 1);

        // R10 postpone: five intervals without grant, saturates at three.
        repeat (5 * INTERVAL) @(negedge clk);
        check(req === 1'b1, "R10", "request while postponed", req, 1);
        check(own === 1'b0, "R10", "bus not taken while postponed", own, 0);
        push(-1, -1, "R10");
        push(PRE, SPACE, "R10");
        push(PRE, SPACE, "R10");
        gnt = 1'b1;
        drain();
        gnt = 1'b0;
        repeat (10) @(negedge clk);
        check(req === 1'b0, "R10", "request low after drain", req, 0);
        check(own === 1'b0, "R10", "bus released after burst", own, 0);

        check(we_bad == 0, "R6", "WE low samples", we_bad, 0);
        check(own_bad == 0, "R8", "strobe without grant/own", own_bad, 0);
        check(pause_bad == 0, "R2", "activity in pause", pause_bad, 0);
        finish_run();
    end

endmodule